// File: doc/BRIEF.md
# Receive Serial Bit-Clock Output Interface

This block sits between a receive demodulator and an external host. The demodulator hands it demodulated octets, each tagged with a flag that marks the octets of the 16-bit header checksum. It also gives a one-cycle strobe when the start-frame delimiter is found and one-cycle strobes for end of packet and loss of carrier. The block presents the octets to the host as a serial data line with a gated bit clock and a data-ready level that frames the payload.

The bit clock runs only inside a frame. Its rate is chosen by a rate code, which is captured when the frame starts. Each bit period has two halves. The first half is low, and the data line changes at its start. The second half is high, so the host can sample on the rising edge. During checksum octets the clock stays at its inactive level. An output polarity input inverts the clock. A stop request ends the frame at the next bit boundary, so every clock pulse that reaches the output has full width.

Top module: `rxs_serial_out`

## Requirements
- R1: After reset, and at all times while no frame is active, the clock output rests at the level of `clk_inv`, and `rxd` and `data_rdy` are 0.
- R2: Each octet is sent least significant bit first. One bit is sent per clock pulse, and octets go out in the order they were written.
- R3: Before `sfd_det` the clock output does not toggle, even while octets are being written.
- R4: Octets written with `byte_crc`=1 after the header produce no clock pulse, and the clock stays at its inactive level for their 8 bit periods.
- R5: With `clk_inv`=1 the clock output is the exact complement of the non-inverted clock, including its idle level.
- R6: Each half bit period lasts HALF_UNIT<<`rate_sel` cycles, using the `rate_sel` value captured in the `sfd_det` cycle. Changes to `rate_sel` inside a frame have no effect.
- R7: `rxd` changes only while the non-inverted clock is low, so it is stable for the whole high half.
- R8: `data_rdy` is 0 during header and checksum bits. It is 1 from the first payload bit through the last one, and it changes only while the non-inverted clock is low.
- R9: An `eop` strobe ends the frame at the next bit boundary. The bit in progress finishes its full clock pulse, and then the block is idle (as in R1).
- R10: A `carrier_lost` strobe returns the block to idle within 2*HALF_UNIT<<rate cycles. Every high pulse on the clock lasts exactly one half period.
- R11: `sfd_det` during an active frame is ignored: the bit stream and its timing do not change.
- R12: The first header octet may be written in the same cycle as `sfd_det`, and its bit 0 is the first bit sent. The first octet after the strobe is always header, and the first octet without the checksum flag that follows checksum octets begins the payload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_sel | input | RATE_W | Rate code; half period = HALF_UNIT<<rate_sel cycles |
| clk_inv | input | 1 | Invert the output bit clock |
| sfd_det | input | 1 | Start-frame delimiter found (one-cycle strobe) |
| byte_wr | input | 1 | Write strobe for the next octet |
| byte_data | input | 8 | Next octet to send |
| byte_crc | input | 1 | The written octet belongs to the header checksum |
| eop | input | 1 | End of packet strobe |
| carrier_lost | input | 1 | Abort strobe on loss of carrier |
| rxd | output | 1 | Serial data to the host |
| rxclk | output | 1 | Gated bit clock to the host |
| data_rdy | output | 1 | High while payload bits are sent |

## Verification
The assertions assume that `clk_inv` is held constant while a frame is active. They also assume that each octet after the first is written before the boundary that loads it, since the block has only one holding register and reports no underrun. The stimulus changes polarity and rate only between frames, after the idle check. It writes octet k exactly one half period after octet k-1 has been loaded, so every load finds a fresh value. Random frames vary header and payload length, rate, polarity and abort time, and some of them inject a spurious delimiter strobe and a rate change in the middle of the frame.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

    localparam int BYTE_BITS = 8;
    localparam int IDX_W     = $clog2(BYTE_BITS);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HDR  = 2'd1,
        ST_CRC  = 2'd2,
        ST_PAY  = 2'd3
    } rx_state_e;

    typedef struct packed {
        logic                 crc;
        logic [BYTE_BITS-1:0] data;
    } rx_byte_t;

    // Longest half period: unit scaled by the largest rate code.
    function automatic int max_half(int unit, int rate_w);
        return unit << ((1 << rate_w) - 1);
    endfunction

endpackage

// File: rtl/rxs_bit_timer.sv
module rxs_bit_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [CNT_W-1:0] half_len,
    output logic             phase,
    output logic             boundary
);

    logic [CNT_W-1:0] cnt;
    logic             half_end;

    assign half_end = (cnt == half_len - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt   <= '0;
            phase <= 1'b0;
        end else if (half_end) begin
            cnt   <= '0;
            phase <= ~phase;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    // End of the high half: next edge starts a new bit.
    assign boundary = run && phase && half_end;

endmodule

// File: rtl/rxs_byte_shifter.sv
module rxs_byte_shifter
    import rxs_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr,
    input  rx_byte_t wr_byte,
    input  logic     load,
    input  logic     shift,
    output logic     cur_bit,
    output logic     last_bit,
    output logic     next_crc
);

    rx_byte_t             hold_q;
    rx_byte_t             src;
    logic [BYTE_BITS-1:0] sh_q;
    logic [IDX_W-1:0]     idx_q;

    // A write in the load cycle bypasses the holding register.
    assign src = wr ? wr_byte : hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            sh_q   <= '0;
            idx_q  <= '0;
        end else begin
            if (wr) begin
                hold_q <= wr_byte;
            end
            if (load) begin
                sh_q  <= src.data;
                idx_q <= '0;
            end else if (shift) begin
                sh_q  <= sh_q >> 1;
                idx_q <= idx_q + IDX_W'(1);
            end
        end
    end

    assign cur_bit  = sh_q[0];
    assign last_bit = (idx_q == IDX_W'(BYTE_BITS - 1));
    assign next_crc = src.crc;

endmodule

// File: rtl/rxs_frame_ctrl.sv
module rxs_frame_ctrl
    import rxs_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sfd,
    input  logic      boundary,
    input  logic      last_bit,
    input  logic      next_crc,
    input  logic      stop_req,
    output rx_state_e state,
    output logic      start,
    output logic      load,
    output logic      shift
);

    rx_state_e state_q;
    logic      pend_q;
    logic      stop_now;
    logic      byte_end;

    assign start    = (state_q == ST_IDLE) && sfd;
    assign stop_now = boundary && (pend_q || stop_req);
    assign byte_end = boundary && !stop_now && last_bit;
    assign load     = start || byte_end;
    assign shift    = boundary && !stop_now && !last_bit;
    assign state    = state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            pend_q  <= 1'b0;
        end else begin
            if (state_q == ST_IDLE || stop_now) begin
                pend_q <= 1'b0;
            end else if (stop_req) begin
                pend_q <= 1'b1;
            end

            if (start) begin
                state_q <= ST_HDR;
            end else if (stop_now) begin
                state_q <= ST_IDLE;
            end else if (byte_end) begin
                case (state_q)
                    ST_HDR:  if (next_crc)  state_q <= ST_CRC;
                    ST_CRC:  if (!next_crc) state_q <= ST_PAY;
                    default: state_q <= state_q;
                endcase
            end
        end
    end

endmodule

// File: rtl/rxs_serial_out.sv
module rxs_serial_out
    import rxs_pkg::*;
#(
    parameter int  HALF_UNIT = 2,
    parameter int  RATE_W    = 2,
    localparam int MAX_HALF  = max_half(HALF_UNIT, RATE_W),
    localparam int CNT_W     = $clog2(MAX_HALF + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic              clk_inv,
    input  logic              sfd_det,
    input  logic              byte_wr,
    input  logic [7:0]        byte_data,
    input  logic              byte_crc,
    input  logic              eop,
    input  logic              carrier_lost,
    output logic              rxd,
    output logic              rxclk,
    output logic              data_rdy
);

    rx_state_e         state;
    logic              start;
    logic              load;
    logic              shift;
    logic              phase;
    logic              boundary;
    logic              cur_bit;
    logic              last_bit;
    logic              next_crc;
    logic              clk_on;
    logic [RATE_W-1:0] rate_q;
    logic [CNT_W-1:0]  half_len;
    rx_byte_t          wr_byte;

    assign wr_byte  = '{crc: byte_crc, data: byte_data};
    assign half_len = CNT_W'(HALF_UNIT) << rate_q;

    // Rate is frozen for the whole frame.
    always_ff @(posedge clk) begin
        if (rst) begin
            rate_q <= '0;
        end else if (start) begin
            rate_q <= rate_sel;
        end
    end

    rxs_frame_ctrl i_ctrl (
        .clk      (clk),
        .rst      (rst),
        .sfd      (sfd_det),
        .boundary (boundary),
        .last_bit (last_bit),
        .next_crc (next_crc),
        .stop_req (eop || carrier_lost),
        .state    (state),
        .start    (start),
        .load     (load),
        .shift    (shift)
    );

    rxs_bit_timer #(.CNT_W(CNT_W)) i_timer (
        .clk      (clk),
        .rst      (rst),
        .run      (state != ST_IDLE),
        .half_len (half_len),
        .phase    (phase),
        .boundary (boundary)
    );

    rxs_byte_shifter i_shift (
        .clk      (clk),
        .rst      (rst),
        .wr       (byte_wr),
        .wr_byte  (wr_byte),
        .load     (load),
        .shift    (shift),
        .cur_bit  (cur_bit),
        .last_bit (last_bit),
        .next_crc (next_crc)
    );

    // State and phase both change only at a bit boundary, where phase
    // returns low, so gating never cuts a pulse short.
    assign clk_on   = (state == ST_HDR) || (state == ST_PAY);
    assign rxclk    = (phase && clk_on) ^ clk_inv;
    assign rxd      = clk_on && cur_bit;
    assign data_rdy = (state == ST_PAY);

endmodule

// File: rtl/rxs_serial_out_chk.sv
module rxs_serial_out_chk
    import rxs_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             clk_inv,
    input logic             rxclk,
    input logic             rxd,
    input logic             data_rdy,
    input rx_state_e        state,
    input logic [CNT_W-1:0] half_len
);

    logic             raw;
    logic [CNT_W-1:0] hi_cnt;

    assign raw = rxclk ^ clk_inv;

    always_ff @(posedge clk) begin
        if (rst || !raw) begin
            hi_cnt <= '0;
        end else begin
            hi_cnt <= hi_cnt + CNT_W'(1);
        end
    end

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> (!raw && !rxd && !data_rdy));

    a_r4_crc_gated: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CRC) |-> !raw);

    a_r7_data_hold: assert property (@(posedge clk) disable iff (rst)
        (raw && $past(raw)) |-> $stable(rxd));

    a_r8_rdy_moves_low: assert property (@(posedge clk) disable iff (rst)
        (data_rdy != $past(data_rdy)) |-> !raw);

    a_r10_full_pulse: assert property (@(posedge clk) disable iff (rst)
        (!raw && hi_cnt != '0) |-> (hi_cnt == half_len));

    a_r6_rate_frozen: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE && $past(state) != ST_IDLE) |-> $stable(half_len));

endmodule

bind rxs_serial_out rxs_serial_out_chk #(.CNT_W(CNT_W)) i_chk (
    .clk      (clk),
    .rst      (rst),
    .clk_inv  (clk_inv),
    .rxclk    (rxclk),
    .rxd      (rxd),
    .data_rdy (data_rdy),
    .state    (state),
    .half_len (half_len)
);

// File: tb/test_rxs_serial_out.sv
module test_rxs_serial_out;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int HALF_UNIT = 2;
    localparam int RATE_W    = 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [RATE_W-1:0] rate_sel = '0;
    logic              inv_cur = 1'b0;
    logic              sfd_det = 1'b0;
    logic              byte_wr = 1'b0;
    logic [7:0]        byte_data = '0;
    logic              byte_crc = 1'b0;
    logic              eop = 1'b0;
    logic              carrier_lost = 1'b0;
    logic              rxd;
    logic              rxclk;
    logic              data_rdy;

    int checks = 0;
    int errors = 0;

    logic [7:0] fbytes [0:15];
    logic       cap_bit [0:255];
    logic       cap_rdy [0:255];
    int         ncap = 0;
    int         h_exp = 2;
    logic       prev_raw = 1'b0;
    logic       prev_rxd = 1'b0;
    logic       raw_s;
    int         width = 0;

    always #10 clk = ~clk;

    rxs_serial_out #(.HALF_UNIT(HALF_UNIT), .RATE_W(RATE_W)) i_rxs_serial_out (
        .clk          (clk),
        .rst          (rst),
        .rate_sel     (rate_sel),
        .clk_inv      (inv_cur),
        .sfd_det      (sfd_det),
        .byte_wr      (byte_wr),
        .byte_data    (byte_data),
        .byte_crc     (byte_crc),
        .eop          (eop),
        .carrier_lost (carrier_lost),
        .rxd          (rxd),
        .rxclk        (rxclk),
        .data_rdy     (data_rdy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Host model: samples on the rising edge of the non-inverted clock.
    always begin
        @(posedge clk);
        #5;
        if (!rst) begin
            raw_s = rxclk ^ inv_cur;
            if (raw_s && !prev_raw) begin
                if (ncap < 256) begin
                    cap_bit[ncap] = rxd;
                    cap_rdy[ncap] = data_rdy;
                end
                ncap++;
                width = 1;
            end else if (raw_s && prev_raw) begin
                chk(rxd == prev_rxd, "R7", int'(rxd), int'(prev_rxd));
                width++;
            end else if (!raw_s && prev_raw) begin
                chk(width == h_exp, "R6", width, h_exp);
            end
            prev_raw = raw_s;
            prev_rxd = rxd;
        end
    end

    function automatic logic exp_bit(int i, int nh);
        if (i < nh * 8) return fbytes[i / 8][i % 8];
        return fbytes[nh + 2 + (i - nh * 8) / 8][(i - nh * 8) % 8];
    endfunction

    task automatic check_idle(input string req);
        chk(rxclk == inv_cur, req, int'(rxclk), int'(inv_cur));
        chk(rxd == 1'b0, req, int'(rxd), 0);
        chk(data_rdy == 1'b0, req, int'(data_rdy), 0);
    endtask

    task automatic run_frame(input int nh, input int np, input int rate,
                             input bit inv, input bit abort, input bit extra);
        int last_idx;
        int h;
        int t_eop;
        int t_abort;
        int t_end;
        int nexp;
        string req;
        last_idx = nh + 2 + np - 1;
        h = HALF_UNIT << rate;
        for (int k = 0; k <= last_idx; k++) fbytes[k] = 8'($urandom);
        @(negedge clk);
        inv_cur  = inv;
        rate_sel = RATE_W'(rate);
        h_exp    = h;
        ncap     = 0;
        t_eop    = 16 * h * last_idx + 15 * h + 1;
        t_abort  = abort ? 16 * h * (nh + 2) + int'($urandom % (16 * h * np)) : -1;
        t_end    = abort ? t_abort + 2 * h + 3 : 16 * h * (last_idx + 1) + 3;
        for (int t = 0; t < t_end; t++) begin
            sfd_det      = (t == 0);
            byte_wr      = 1'b0;
            eop          = (!abort && t == t_eop);
            carrier_lost = (t == t_abort);
            if (t == 0) begin
                byte_wr   = 1'b1;
                byte_data = fbytes[0];
                byte_crc  = 1'b0;
            end else if (t >= h && (t - h) % (16 * h) == 0 && (t - h) / (16 * h) + 1 <= last_idx) begin
                byte_wr   = 1'b1;
                byte_data = fbytes[(t - h) / (16 * h) + 1];
                byte_crc  = ((t - h) / (16 * h) + 1 >= nh) && ((t - h) / (16 * h) + 1 < nh + 2);
            end
            if (extra && t == 16 * h + 3) begin
                sfd_det  = 1'b1;
                rate_sel = ~RATE_W'(rate);
            end
            if (t == t_end - 1) check_idle(abort ? "R10" : "R9");
            @(negedge clk);
        end
        sfd_det = 1'b0; byte_wr = 1'b0; eop = 1'b0; carrier_lost = 1'b0;
        repeat (3) @(negedge clk);
        chk(rxclk == inv_cur, "R5", int'(rxclk), int'(inv_cur));
        nexp = (nh + np) * 8;
        if (!abort) chk(ncap == nexp, extra ? "R11" : "R4", ncap, nexp);
        else        chk(ncap <= nexp, "R10", ncap, nexp);
        for (int i = 0; i < ncap && i < 256; i++) begin
            req = (i < 8) ? "R12" : "R2";
            chk(cap_bit[i] == exp_bit(i, nh), req, int'(cap_bit[i]), int'(exp_bit(i, nh)));
            chk(cap_rdy[i] == (i >= nh * 8), "R8", int'(cap_rdy[i]), int'(i >= nh * 8));
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_idle("R1");

        // R3: octet writes without a delimiter leave the clock quiet.
        ncap = 0;
        for (int t = 0; t < 40; t++) begin
            byte_wr   = (t % 7 == 0);
            byte_data = 8'($urandom);
            @(negedge clk);
        end
        byte_wr = 1'b0;
        chk(ncap == 0, "R3", ncap, 0);
        chk(rxclk == inv_cur, "R3", int'(rxclk), int'(inv_cur));

        // Directed corners.
        run_frame(1, 1, 0, 1'b0, 1'b0, 1'b0);
        run_frame(3, 2, 3, 1'b1, 1'b0, 1'b1);
        run_frame(2, 3, 1, 1'b0, 1'b1, 1'b0);
        run_frame(1, 2, 0, 1'b1, 1'b1, 1'b1);

        // Random frames.
        for (int n = 0; n < 18; n++) begin
            run_frame(1 + int'($urandom % 3), 1 + int'($urandom % 4),
                      int'($urandom % 4), 1'($urandom), 1'($urandom % 3 == 0),
                      1'($urandom % 2));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule